// File: doc/BRIEF.md
# Two-Requester Shared Byte Memory Arbiter

This block decides which of two processors may use one byte-wide RAM for a given memory cycle. The first requester is a host on an asynchronous request/acknowledge bus. It receives a data-transfer acknowledge once its access is complete. The second requester is a local 8-bit microprocessor, which receives a ready indication instead. The RAM array sits outside the block. The block drives the RAM address, write data and active-low write strobe, and it controls the enable and direction of the data-bus transceiver.

A divider runs from the fast clock and produces a slow system clock. Request lines are looked at only when that slow clock is low. At such a sample point an access-select decision names the owner, and the host wins whenever it is requesting. The owner's address, write data and read/write choice are captured at the grant. One strobe cycle then performs the access. The block then waits in a hold state, acknowledging the owner, until that owner withdraws its request. Only after that does it return to idle and release the transceiver. Only the low byte of the host's 16-bit data bus reaches the memory.

Top module: `shmem_arbiter`

## Requirements
- R1: A new cycle (busy_o rising) starts only on a clock edge at which sclk_o was low, and never while a cycle is already running.
- R2: When host_req_i and loc_req_i are both high at a sample point, the host gets the cycle (owner_o = 0). The pending local request is granted at one of the next DIV sample-eligible edges after the host's cycle ends, with owner_o = 1.
- R3: The host read/write choice (host_we_i = 1 means write) is captured at the grant. Changing host_we_i or host_wdata_i later in the cycle changes neither the strobe nor the stored data.
- R4: A host write stores host_wdata_i (the low byte lane). A host read returns the byte on host_rdata_o[7:0] with host_rdata_o[15:8] = 0.
- R5: ram_we_no is low for exactly one clock in a write cycle and returns high before any acknowledge. It stays high for the whole of a read cycle.
- R6: host_dtack_o is asserted only in a cycle the host owns. It is never high together with loc_ready_o, and never during a local cycle.
- R7: Once acknowledged, the cycle stays busy with its acknowledge high for as long as the owner keeps its request high. One clock after the request drops, busy_o and xcvr_en_o are both low.
- R8: While a cycle is busy, a request from the other side is not granted and owner_o does not change.
- R9: During a local cycle, xcvr_dir_o follows the local read strobe (loc_rd_i = 1 means read, direction 0 = memory to processor). loc_rdata_o returns the stored byte.
- R10: After reset busy_o, xcvr_en_o, host_dtack_o and loc_ready_o are 0, ram_we_no is 1, and sclk_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host memory request, high = requesting |
| host_we_i | input | 1 | Host read/write, 1 = write |
| host_addr_i | input | ADDR_W | Host word address into shared RAM |
| host_wdata_i | input | 8 | Host low data byte lane for writes |
| host_rdata_o | output | 16 | Host read data, upper byte zero |
| host_dtack_o | output | 1 | Acknowledge to the host |
| loc_req_i | input | 1 | Local processor memory request |
| loc_rd_i | input | 1 | Local read strobe, 1 = read |
| loc_addr_i | input | ADDR_W | Local address |
| loc_wdata_i | input | 8 | Local write data |
| loc_rdata_o | output | 8 | Local read data |
| loc_ready_o | output | 1 | Access complete indication to local side |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, combinational from address |
| ram_we_no | output | 1 | RAM write strobe, active low |
| xcvr_en_o | output | 1 | Transceiver enable, high while a cycle runs |
| xcvr_dir_o | output | 1 | Transceiver direction, 1 = toward memory |
| busy_o | output | 1 | Cycle-in-progress flag |
| owner_o | output | 1 | Current owner, 0 = host, 1 = local |
| sclk_o | output | 1 | Divided system clock |

## Verification
The assertions assume that a requester keeps its request high until it has seen its own acknowledge. They also assume that the local read strobe does not change during a local cycle, and that the RAM returns read data combinationally from the address. The bench drives all inputs at the falling clock edge. Each access task raises a request, waits for the matching acknowledge, and only then drops the request, so no request is ever withdrawn early. loc_rd_i is set before the local request rises and left alone until that request has fallen. The RAM model reads asynchronously and writes on the rising edge while the strobe is low.

// File: rtl/shmem_arb_pkg.sv
package shmem_arb_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_STRB = 2'd1,
    CYC_HOLD = 2'd2
  } cyc_state_e;

  typedef enum logic {
    OWN_HOST  = 1'b0,
    OWN_LOCAL = 1'b1
  } owner_e;
endpackage

// File: rtl/shmem_sample_gen.sv
module shmem_sample_gen #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sample_o,
  output logic sclk_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // request lines are looked at only while the slow clock is low
  assign sample_o = (cnt_q == '0);
  assign sclk_o   = (cnt_q >= HALF);
endmodule

// File: rtl/shmem_access_sel.sv
module shmem_access_sel (
  input  logic host_req_i,
  input  logic loc_req_i,
  output logic grant_any_o,
  output logic grant_local_o
);
  logic sel_d;

  // select input low hands the cycle to the host, high defaults to local
  assign sel_d         = ~host_req_i;
  assign grant_any_o   = host_req_i | loc_req_i;
  assign grant_local_o = sel_d & loc_req_i;
endmodule

// File: rtl/shmem_cycle_fsm.sv
module shmem_cycle_fsm
  import shmem_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sample_i,
  input  logic       grant_any_i,
  input  logic       grant_local_i,
  input  logic       host_req_i,
  input  logic       loc_req_i,
  output cyc_state_e state_o,
  output owner_e     owner_o,
  output logic       start_o
);
  cyc_state_e state_q, state_d;
  owner_e     owner_q;
  logic       own_req;

  assign own_req = (owner_q == OWN_HOST) ? host_req_i : loc_req_i;
  assign start_o = (state_q == CYC_IDLE) && sample_i && grant_any_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CYC_IDLE: if (start_o) state_d = CYC_STRB;
      CYC_STRB: state_d = CYC_HOLD;
      CYC_HOLD: if (!own_req) state_d = CYC_IDLE;
      default:  state_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CYC_IDLE;
      owner_q <= OWN_HOST;
    end else begin
      state_q <= state_d;
      if (start_o) owner_q <= grant_local_i ? OWN_LOCAL : OWN_HOST;
    end
  end

  assign state_o = state_q;
  assign owner_o = owner_q;
endmodule

// File: rtl/shmem_datapath.sv
module shmem_datapath
  import shmem_arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              grant_local_i,
  input  cyc_state_e        state_i,
  input  owner_e            owner_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DW-1:0]     host_wdata_i,
  input  logic              loc_rd_i,
  input  logic [ADDR_W-1:0] loc_addr_i,
  input  logic [DW-1:0]     loc_wdata_i,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DW-1:0]     ram_wdata_o,
  output logic              ram_we_no,
  output logic              xcvr_en_o,
  output logic              xcvr_dir_o,
  output logic [DW-1:0]     rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q, rdata_q;
  logic              host_wr_q, loc_wr_q;
  logic              busy, cyc_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      host_wr_q <= 1'b0;
      loc_wr_q  <= 1'b0;
    end else if (start_i) begin
      addr_q    <= grant_local_i ? loc_addr_i  : host_addr_i;
      wdata_q   <= grant_local_i ? loc_wdata_i : host_wdata_i;
      // host rw latch stays inactive for a local cycle
      host_wr_q <= grant_local_i ? 1'b0 : host_we_i;
      loc_wr_q  <= grant_local_i ? ~loc_rd_i : 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                rdata_q <= '0;
    else if (state_i == CYC_STRB && !cyc_wr)    rdata_q <= ram_rdata_i;
  end

  assign busy        = (state_i != CYC_IDLE);
  assign cyc_wr      = (owner_i == OWN_HOST) ? host_wr_q : loc_wr_q;
  assign ram_addr_o  = addr_q;
  assign ram_wdata_o = wdata_q;
  assign ram_we_no   = ~((state_i == CYC_STRB) && cyc_wr);
  assign xcvr_en_o   = busy;
  assign xcvr_dir_o  = busy && ((owner_i == OWN_HOST) ? host_wr_q : ~loc_rd_i);
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/shmem_arbiter.sv
module shmem_arbiter
  import shmem_arb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DIV    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [7:0]        host_wdata_i,
  output logic [15:0]       host_rdata_o,
  output logic              host_dtack_o,
  input  logic              loc_req_i,
  input  logic              loc_rd_i,
  input  logic [ADDR_W-1:0] loc_addr_i,
  input  logic [7:0]        loc_wdata_i,
  output logic [7:0]        loc_rdata_o,
  output logic              loc_ready_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  input  logic [7:0]        ram_rdata_i,
  output logic              ram_we_no,
  output logic              xcvr_en_o,
  output logic              xcvr_dir_o,
  output logic              busy_o,
  output logic              owner_o,
  output logic              sclk_o
);
  localparam int DW = 8;

  logic       sample, grant_any, grant_local, start;
  cyc_state_e state;
  owner_e     owner;
  logic [DW-1:0] rdata;

  shmem_sample_gen #(.DIV(DIV)) u_sample (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_o(sample), .sclk_o(sclk_o)
  );

  shmem_access_sel u_sel (
    .host_req_i(host_req_i), .loc_req_i(loc_req_i),
    .grant_any_o(grant_any), .grant_local_o(grant_local)
  );

  shmem_cycle_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample),
    .grant_any_i(grant_any), .grant_local_i(grant_local),
    .host_req_i(host_req_i), .loc_req_i(loc_req_i),
    .state_o(state), .owner_o(owner), .start_o(start)
  );

  shmem_datapath #(.ADDR_W(ADDR_W), .DW(DW)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .grant_local_i(grant_local),
    .state_i(state), .owner_i(owner),
    .host_we_i(host_we_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
    .loc_rd_i(loc_rd_i), .loc_addr_i(loc_addr_i), .loc_wdata_i(loc_wdata_i),
    .ram_rdata_i(ram_rdata_i), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
    .ram_we_no(ram_we_no), .xcvr_en_o(xcvr_en_o), .xcvr_dir_o(xcvr_dir_o),
    .rdata_o(rdata)
  );

  assign busy_o       = (state != CYC_IDLE);
  assign owner_o      = owner;
  assign host_dtack_o = (state == CYC_HOLD) && (owner == OWN_HOST);
  assign loc_ready_o  = (state == CYC_HOLD) && (owner == OWN_LOCAL);
  assign host_rdata_o = {8'h00, rdata};
  assign loc_rdata_o  = rdata;
endmodule

// File: rtl/shmem_arbiter_chk.sv
module shmem_arbiter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic host_req_i,
  input logic loc_req_i,
  input logic loc_rd_i,
  input logic host_dtack_o,
  input logic loc_ready_o,
  input logic ram_we_no,
  input logic xcvr_en_o,
  input logic xcvr_dir_o,
  input logic busy_o,
  input logic owner_o,
  input logic sclk_o
);
  assert_grant_on_low_sclk_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(sclk_o));

  assert_host_wins_tie_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) && $past(host_req_i) |-> !owner_o);

  assert_strobe_one_clock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |=> ram_we_no);

  assert_strobe_drives_toward_ram_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |-> xcvr_en_o && xcvr_dir_o);

  assert_single_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_dtack_o && loc_ready_o));

  assert_dtack_host_owned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_dtack_o |-> !owner_o && $past(host_req_i));

  assert_hold_while_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (owner_o ? loc_req_i : host_req_i) |=> busy_o);

  assert_owner_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(owner_o));

  assert_local_dir_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && owner_o |-> xcvr_dir_o == !loc_rd_i);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ram_we_no && !xcvr_en_o && !host_dtack_o && !loc_ready_o);
endmodule

bind shmem_arbiter shmem_arbiter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_req_i(host_req_i), .loc_req_i(loc_req_i),
  .loc_rd_i(loc_rd_i), .host_dtack_o(host_dtack_o), .loc_ready_o(loc_ready_o),
  .ram_we_no(ram_we_no), .xcvr_en_o(xcvr_en_o), .xcvr_dir_o(xcvr_dir_o),
  .busy_o(busy_o), .owner_o(owner_o), .sclk_o(sclk_o)
);

// File: tb/shmem_arbiter_tb_top.sv
`timescale 1ns/1ps
module shmem_arbiter_tb_top;
  localparam int ADDR_W = 10;
  localparam int DIV    = 2;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic host_req_i = 0, host_we_i = 0, loc_req_i = 0, loc_rd_i = 1;
  logic [ADDR_W-1:0] host_addr_i = '0, loc_addr_i = '0;
  logic [7:0] host_wdata_i = '0, loc_wdata_i = '0;
  logic [15:0] host_rdata_o;
  logic [7:0] loc_rdata_o, ram_wdata_o, ram_rdata_i;
  logic [ADDR_W-1:0] ram_addr_o;
  logic host_dtack_o, loc_ready_o, ram_we_no, xcvr_en_o, xcvr_dir_o, busy_o, owner_o, sclk_o;

  int checks = 0, failures = 0;
  logic [7:0] mem  [DEPTH];
  logic [7:0] refm [DEPTH];
  int we_low_cnt = 0;
  logic prev_sclk = 0, prev_busy = 0;

  always #2 clk_i = ~clk_i;

  shmem_arbiter #(.ADDR_W(ADDR_W), .DIV(DIV)) dut_i (.*);

  assign ram_rdata_i = mem[ram_addr_o];
  always @(posedge clk_i) if (!ram_we_no) mem[ram_addr_o] <= ram_wdata_o;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // port monitor: grant timing and acknowledge exclusivity
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!ram_we_no) we_low_cnt++;
      if (busy_o && !prev_busy) chk(prev_sclk == 1'b0, "R1 grant on low sclk", prev_sclk, 0);
      if (host_dtack_o && (owner_o || loc_ready_o)) chk(0, "R6 dtack in local cycle", 1, 0);
      prev_sclk = sclk_o;
      prev_busy = busy_o;
    end
  end

  task automatic host_access(input bit we, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                             input bit flip, input int hold, output logic [15:0] rd);
    int n = 0;
    @(negedge clk_i);
    host_we_i = we; host_addr_i = a; host_wdata_i = d; host_req_i = 1;
    we_low_cnt = 0;
    do begin
      @(negedge clk_i); n++;
      if (flip && busy_o) begin host_we_i = ~we; host_wdata_i = ~d; end
    end while (!host_dtack_o && n < 50);
    chk(host_dtack_o, "R6 host dtack seen", host_dtack_o, 1);
    chk(we_low_cnt == (we ? 1 : 0), "R5 strobe clocks", we_low_cnt, we ? 1 : 0);
    rd = host_rdata_o;
    if (we) refm[a] = d;
    repeat (hold) begin
      @(negedge clk_i);
      if (!(busy_o && host_dtack_o)) chk(0, "R7 held while requested", busy_o, 1);
    end
    host_req_i = 0;
    @(negedge clk_i);
    chk(!busy_o && !xcvr_en_o, "R7 release", {busy_o, xcvr_en_o}, 0);
  endtask

  task automatic loc_access(input bit rd_n, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                            output logic [7:0] rd);
    int n = 0;
    @(negedge clk_i);
    loc_rd_i = rd_n; loc_addr_i = a; loc_wdata_i = d; loc_req_i = 1;
    we_low_cnt = 0;
    do begin @(negedge clk_i); n++; end while (!loc_ready_o && n < 50);
    chk(loc_ready_o && !host_dtack_o, "R6 local ready, no dtack", {loc_ready_o, host_dtack_o}, 2);
    chk(xcvr_dir_o == !rd_n, "R9 local direction", xcvr_dir_o, !rd_n);
    chk(we_low_cnt == (rd_n ? 0 : 1), "R5 local strobe", we_low_cnt, rd_n ? 0 : 1);
    rd = loc_rdata_o;
    if (!rd_n) refm[a] = d;
    loc_req_i = 0;
    @(negedge clk_i);
    loc_rd_i = 1;
  endtask

  task automatic t_reset;
    chk(!busy_o && !xcvr_en_o && !host_dtack_o && !loc_ready_o && ram_we_no && !sclk_o,
        "R10 reset state", {busy_o, xcvr_en_o, host_dtack_o, loc_ready_o, ram_we_no, sclk_o}, 6'b000010);
  endtask

  task automatic t_host_rw;
    logic [15:0] r;
    host_access(1, 10'h005, 8'h5C, 0, 0, r);
    host_access(0, 10'h005, 8'h00, 0, 0, r);
    chk(r == {8'h00, refm[10'h005]}, "R4 host readback low lane", r, {8'h00, refm[10'h005]});
    host_access(1, 10'h3FF, 8'hA7, 0, 2, r);
    host_access(0, 10'h3FF, 8'h00, 0, 0, r);
    chk(r == 16'h00A7, "R4 upper byte zero", r, 16'h00A7);
  endtask

  task automatic t_local_rw;
    logic [7:0] r;
    logic [15:0] h;
    loc_access(0, 10'h020, 8'h3E, r);
    loc_access(1, 10'h020, 8'h00, r);
    chk(r == refm[10'h020], "R9 local readback", r, refm[10'h020]);
    host_access(0, 10'h020, 8'h00, 0, 0, h);
    chk(h == {8'h00, refm[10'h020]}, "R4 host sees local write", h, {8'h00, refm[10'h020]});
    loc_access(1, 10'h005, 8'h00, r);
    chk(r == refm[10'h005], "R9 local sees host write", r, refm[10'h005]);
  endtask

  task automatic t_latch;
    logic [15:0] r;
    host_access(1, 10'h111, 8'h96, 1, 1, r);
    host_access(0, 10'h111, 8'h00, 0, 0, r);
    chk(r == 16'h0096, "R3 late rw/data change ignored", r, 16'h0096);
  endtask

  task automatic t_tie;
    int n = 0, idle = 0;
    refm[10'h0AA] = 8'hC3; refm[10'h0AB] = 8'h18;
    @(negedge clk_i);
    host_we_i = 1; host_addr_i = 10'h0AA; host_wdata_i = 8'hC3; host_req_i = 1;
    loc_rd_i = 0;  loc_addr_i = 10'h0AB;  loc_wdata_i = 8'h18;  loc_req_i = 1;
    do begin @(negedge clk_i); n++; end while (!busy_o && n < 20);
    chk(busy_o && owner_o == 1'b0, "R2 host wins tie", owner_o, 0);
    do begin @(negedge clk_i); n++; end while (!host_dtack_o && n < 40);
    repeat (3) @(negedge clk_i);
    chk(owner_o == 1'b0 && !loc_ready_o, "R8 local held off", {owner_o, loc_ready_o}, 0);
    host_req_i = 0;
    do begin @(negedge clk_i); if (!busy_o) idle++; n++; end while (!busy_o || idle == 0) ;
    chk(idle >= 1 && idle <= DIV, "R2 local granted at next sample", idle, DIV);
    chk(owner_o == 1'b1, "R2 local owner after host", owner_o, 1);
    do begin @(negedge clk_i); n++; end while (!loc_ready_o && n < 80);
    loc_req_i = 0;
    @(negedge clk_i);
    loc_rd_i = 1;
  endtask

  task automatic t_check_ram;
    logic [15:0] h;
    logic [7:0] r;
    host_access(0, 10'h0AB, 8'h00, 0, 0, h);
    chk(h == {8'h00, refm[10'h0AB]}, "R2 pending local write stored", h, {8'h00, refm[10'h0AB]});
    loc_access(1, 10'h0AA, 8'h00, r);
    chk(r == refm[10'h0AA], "R2 host tie write stored", r, refm[10'h0AA]);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    t_host_rw();
    t_local_rw();
    t_latch();
    t_tie();
    t_check_ram();
    repeat (4) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule